// File: doc/BRIEF.md
# Host Register Access Unit

This unit sits between a host bus and the small register set of a cell interface controller. A register read returns two values at once. A low select code picks one 16-bit register for bits 15:0 of the 32-bit result, and a separate high select code picks one of the external status words for bits 31:16. A read can also carry two flags. A no-reload flag stops the automatic-reload strobe that a read of the arm/preset register normally produces. A clear flag zeroes the violation and header-check failure counters, but only when a status word is selected.

On a register write, a mask carries one bit per general register, so any subset of those registers takes the low data half in the same cycle. An increment address bit on either a register write or a memory write pulses the transmit buffer counter increment. The transmit counter register loads the upper data half only when the data's enable bit is set and the counter-select or increment address bit is set. A memory write can load the counter only through the increment bit.

The unit also keeps a free-running counter. It joins the first status word (bits 31:16) and that counter (bits 15:0) into a timestamp word. The memory array, the interrupt logic and the transmit datapath sit outside this unit and appear only as strobes and ports.

Top module: `hostreg_access`

## Requirements
- R1: While reset is asserted, every general register, the transmit counter, both event counters, the free-running counter, the read data and both output strobes are zero.
- R2: The free-running counter advances by one on every clock and wraps at its width. `timestamp` is status word 0 in bits 31:16 and the zero-extended counter in bits 15:0.
- R3: A read strobe registers the result word, which appears on `rd_data` one cycle later and holds until the next read strobe. Low codes select as follows: 0..NGEN-1 general register (0 is the arm/preset register), NGEN transmit counter, NGEN+1 free-running counter, NGEN+2 violation counter, NGEN+3 header-check failure counter, and any other code gives zero. High code 0 gives zero in bits 31:16, and high code k gives status word k-1.
- R4: `arm_reload` pulses in the cycle after a read whose low code is 0 and whose no-reload flag is clear. No other read pulses it.
- R5: A read with the clear flag set and a nonzero high code zeroes both event counters after the read. The read returns the values from before the clear. With high code 0, the clear flag has no effect.
- R6: The violation and header-check failure counters count their event pulses and hold at all ones instead of wrapping.
- R7: A register write stores `wr_data[15:0]` in every general register whose `wr_mask` bit is set, in the same cycle. Memory writes never change the general registers.
- R8: `tx_inc` pulses in the cycle after any register or memory write with `wr_inc` set, and stays low otherwise.
- R9: The transmit counter takes `wr_data[31:16]` only when `wr_data[EN_BIT]` is 1 and either (a) a register write has `wr_tc_sel` or `wr_inc` set, or (b) a memory write has `wr_inc` set. Otherwise it holds.
- R10: When a counter event and an effective clear happen in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Register read strobe |
| rd_lo_sel | input | LSW | Low-half register select code |
| rd_hi_sel | input | HSW | High-half status select code (0 = none) |
| rd_noreload | input | 1 | Suppress arm reload on this read |
| rd_clear | input | 1 | Clear event counters on this read |
| reg_wr | input | 1 | Register write strobe |
| mem_wr | input | 1 | Memory write strobe |
| wr_mask | input | NGEN | Per-register write enables |
| wr_tc_sel | input | 1 | Transmit counter select address bit |
| wr_inc | input | 1 | Transmit increment address bit |
| wr_data | input | 32 | Write data |
| viol_evt | input | 1 | Violation event pulse |
| hec_evt | input | 1 | Header-check failure event pulse |
| status_in | input | 16*NSTAT | Status words, word k in bits 16k+15:16k |
| rd_data | output | 32 | Registered read result |
| timestamp | output | 32 | Status word 0 and free-running count |
| arm_reload | output | 1 | Arm register reload strobe |
| tx_inc | output | 1 | Transmit buffer counter increment strobe |
| cfg_q | output | 16*NGEN | General register contents |
| tc_q | output | 16 | Transmit counter register |

## Verification
The main decode is driven with single-bit and multi-bit write masks, and with write data that has the enable bit both set and clear. This shows whether the counter load depends on the enable bit, the select bit and the increment bit together, or on any one of them. Memory writes with and without the increment bit show that the two write kinds take different load paths. Reads step through every low code, crossed with every high code and both flags, so that a swapped select field or a flag acting outside its own code shows up. A long mixed phase, with events, reads, clears and writes in the same cycles, exposes priority errors and counter saturation against the reference model.

// File: rtl/hra_pkg.sv
package hra_pkg;
  localparam int unsigned HALF_W = 16;

  // Transmit counter load condition (data enable plus address qualifier)
  function automatic logic tc_load_req(input logic reg_wr, input logic mem_wr,
                                       input logic a_tc, input logic a_inc,
                                       input logic en_bit);
    return en_bit & ((reg_wr & (a_tc | a_inc)) | (mem_wr & a_inc));
  endfunction

  // Transmit increment request from either write kind
  function automatic logic inc_req(input logic reg_wr, input logic mem_wr,
                                   input logic a_inc);
    return (reg_wr | mem_wr) & a_inc;
  endfunction
endpackage

// File: rtl/hra_sat_counter.sv
module hra_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   q <= '0;
    else if (clr)                 q <= '0;
    else if (evt && q != MAXV)    q <= q + 1'b1;
  end
endmodule

// File: rtl/hra_write_decode.sv
module hra_write_decode import hra_pkg::*; #(
  parameter int NGEN   = 3,
  parameter int EN_BIT = 15
) (
  input  logic            reg_wr,
  input  logic            mem_wr,
  input  logic [NGEN-1:0] wr_mask,
  input  logic            wr_tc_sel,
  input  logic            wr_inc,
  input  logic            en_bit,
  output logic [NGEN-1:0] gen_we,
  output logic            tc_load,
  output logic            inc_evt
);
  for (genvar i = 0; i < NGEN; i++) begin : g_we
    assign gen_we[i] = reg_wr & wr_mask[i];
  end

  assign tc_load = tc_load_req(reg_wr, mem_wr, wr_tc_sel, wr_inc, en_bit);
  assign inc_evt = inc_req(reg_wr, mem_wr, wr_inc);
endmodule

// File: rtl/hra_read_mux.sv
module hra_read_mux import hra_pkg::*; #(
  parameter int NGEN  = 3,
  parameter int NSTAT = 3,
  parameter int CNT_W = 16,
  parameter int FRC_W = 16,
  parameter int LSW   = 3,
  parameter int HSW   = 2
) (
  input  logic [NGEN*HALF_W-1:0]  gen_flat,
  input  logic [HALF_W-1:0]       tc_val,
  input  logic [FRC_W-1:0]        frc_val,
  input  logic [CNT_W-1:0]        viol_val,
  input  logic [CNT_W-1:0]        hec_val,
  input  logic [NSTAT*HALF_W-1:0] status_flat,
  input  logic [LSW-1:0]          lo_sel,
  input  logic [HSW-1:0]          hi_sel,
  output logic [2*HALF_W-1:0]     word
);
  logic [HALF_W-1:0] lo_word, hi_word;

  always_comb begin
    lo_word = '0;
    for (int i = 0; i < NGEN; i++)
      if (lo_sel == LSW'(i)) lo_word = gen_flat[i*HALF_W +: HALF_W];
    if (lo_sel == LSW'(NGEN))     lo_word = tc_val;
    if (lo_sel == LSW'(NGEN + 1)) lo_word = HALF_W'(frc_val);
    if (lo_sel == LSW'(NGEN + 2)) lo_word = HALF_W'(viol_val);
    if (lo_sel == LSW'(NGEN + 3)) lo_word = HALF_W'(hec_val);
  end

  always_comb begin
    hi_word = '0;
    for (int k = 0; k < NSTAT; k++)
      if (hi_sel == HSW'(k + 1)) hi_word = status_flat[k*HALF_W +: HALF_W];
  end

  assign word = {hi_word, lo_word};
endmodule

// File: rtl/hostreg_access.sv
module hostreg_access import hra_pkg::*; #(
  parameter int NGEN   = 3,
  parameter int NSTAT  = 3,
  parameter int CNT_W  = 16,
  parameter int FRC_W  = 16,
  parameter int EN_BIT = 15,
  localparam int LSW   = $clog2(NGEN + 5),
  localparam int HSW   = $clog2(NSTAT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_stb,
  input  logic [LSW-1:0]          rd_lo_sel,
  input  logic [HSW-1:0]          rd_hi_sel,
  input  logic                    rd_noreload,
  input  logic                    rd_clear,
  input  logic                    reg_wr,
  input  logic                    mem_wr,
  input  logic [NGEN-1:0]         wr_mask,
  input  logic                    wr_tc_sel,
  input  logic                    wr_inc,
  input  logic [31:0]             wr_data,
  input  logic                    viol_evt,
  input  logic                    hec_evt,
  input  logic [NSTAT*HALF_W-1:0] status_in,
  output logic [31:0]             rd_data,
  output logic [31:0]             timestamp,
  output logic                    arm_reload,
  output logic                    tx_inc,
  output logic [NGEN*HALF_W-1:0]  cfg_q,
  output logic [HALF_W-1:0]       tc_q
);
  // Named internal events (also observed by the bound checker)
  logic [NGEN-1:0]   gen_we;
  logic              tc_load;
  logic              inc_evt;
  logic              clr_evt;
  logic              reload_evt;
  logic [FRC_W-1:0]  frc_q;
  logic [CNT_W-1:0]  viol_q, hec_q;
  logic [31:0]       rd_word;
  logic [1:0]        cnt_evt;
  logic [1:0][CNT_W-1:0] cnt_q;

  assign clr_evt    = rd_stb & rd_clear & (rd_hi_sel != '0);
  assign reload_evt = rd_stb & ~rd_noreload & (rd_lo_sel == '0);

  hra_write_decode #(.NGEN(NGEN), .EN_BIT(EN_BIT)) u_wdec (
    .reg_wr   (reg_wr),
    .mem_wr   (mem_wr),
    .wr_mask  (wr_mask),
    .wr_tc_sel(wr_tc_sel),
    .wr_inc   (wr_inc),
    .en_bit   (wr_data[EN_BIT]),
    .gen_we   (gen_we),
    .tc_load  (tc_load),
    .inc_evt  (inc_evt)
  );

  // Two saturating event counters share one clear
  assign cnt_evt = {hec_evt, viol_evt};
  for (genvar c = 0; c < 2; c++) begin : g_cnt
    hra_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_evt),
      .evt  (cnt_evt[c]),
      .q    (cnt_q[c])
    );
  end
  assign viol_q = cnt_q[0];
  assign hec_q  = cnt_q[1];

  // General registers, one enable each
  for (genvar i = 0; i < NGEN; i++) begin : g_gen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[i*HALF_W +: HALF_W] <= '0;
      else if (gen_we[i]) cfg_q[i*HALF_W +: HALF_W] <= wr_data[HALF_W-1:0];
    end
  end

  hra_read_mux #(
    .NGEN(NGEN), .NSTAT(NSTAT), .CNT_W(CNT_W), .FRC_W(FRC_W),
    .LSW(LSW), .HSW(HSW)
  ) u_rmux (
    .gen_flat   (cfg_q),
    .tc_val     (tc_q),
    .frc_val    (frc_q),
    .viol_val   (viol_q),
    .hec_val    (hec_q),
    .status_flat(status_in),
    .lo_sel     (rd_lo_sel),
    .hi_sel     (rd_hi_sel),
    .word       (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q      <= '0;
      tc_q       <= '0;
      rd_data    <= '0;
      arm_reload <= 1'b0;
      tx_inc     <= 1'b0;
    end else begin
      frc_q      <= frc_q + 1'b1;
      arm_reload <= reload_evt;
      tx_inc     <= inc_evt;
      if (rd_stb)  rd_data <= rd_word;
      if (tc_load) tc_q    <= wr_data[31:16];
    end
  end

  assign timestamp = {status_in[HALF_W-1:0], HALF_W'(frc_q)};
endmodule

// File: rtl/hostreg_access_chk.sv
module hostreg_access_chk #(
  parameter int CNT_W = 16,
  parameter int FRC_W = 16,
  parameter int HSW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_stb,
  input logic [HSW-1:0]   rd_hi_sel,
  input logic             rd_noreload,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             arm_reload,
  input logic             tx_inc,
  input logic [15:0]      tc_q,
  input logic             tc_load,
  input logic             inc_evt,
  input logic             clr_evt,
  input logic [FRC_W-1:0] frc_q,
  input logic [CNT_W-1:0] viol_q,
  input logic [CNT_W-1:0] hec_q
);
  assert_frc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> frc_q == FRC_W'($past(frc_q) + 1'b1));

  assert_hi_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_hi_sel == '0) |=> rd_data[31:16] == 16'h0);

  assert_noreload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_noreload) |=> !arm_reload);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (viol_q == '0 && hec_q == '0));

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && viol_q == '1) |=> viol_q == '1);

  assert_inc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> tx_inc);

  assert_inc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_evt |=> !tx_inc);

  assert_tc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load |=> tc_q == $past(wr_data[31:16]));

  assert_tc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_load |=> $stable(tc_q));
endmodule

bind hostreg_access hostreg_access_chk #(.CNT_W(CNT_W), .FRC_W(FRC_W), .HSW(HSW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_stb     (rd_stb),
  .rd_hi_sel  (rd_hi_sel),
  .rd_noreload(rd_noreload),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .arm_reload (arm_reload),
  .tx_inc     (tx_inc),
  .tc_q       (tc_q),
  .tc_load    (tc_load),
  .inc_evt    (inc_evt),
  .clr_evt    (clr_evt),
  .frc_q      (frc_q),
  .viol_q     (viol_q),
  .hec_q      (hec_q)
);

// File: tb/hostreg_access_tb.sv
`timescale 1ns/1ps
module hostreg_access_tb;
  localparam int NG = 3, NS = 3, CW = 4, FW = 8, ENB = 15;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 0, rd_noreload = 0, rd_clear = 0;
  logic [2:0] rd_lo_sel = '0;
  logic [1:0] rd_hi_sel = '0;
  logic reg_wr = 0, mem_wr = 0, wr_tc_sel = 0, wr_inc = 0;
  logic [NG-1:0] wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic viol_evt = 0, hec_evt = 0;
  logic [NS*16-1:0] status_in = '0;
  logic [31:0] rd_data, timestamp;
  logic arm_reload, tx_inc;
  logic [NG*16-1:0] cfg_q;
  logic [15:0] tc_q;

  always #4 clk = ~clk;

  hostreg_access #(.NGEN(NG), .NSTAT(NS), .CNT_W(CW), .FRC_W(FW), .EN_BIT(ENB)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_lo_sel(rd_lo_sel),
    .rd_hi_sel(rd_hi_sel), .rd_noreload(rd_noreload), .rd_clear(rd_clear),
    .reg_wr(reg_wr), .mem_wr(mem_wr), .wr_mask(wr_mask), .wr_tc_sel(wr_tc_sel),
    .wr_inc(wr_inc), .wr_data(wr_data), .viol_evt(viol_evt), .hec_evt(hec_evt),
    .status_in(status_in), .rd_data(rd_data), .timestamp(timestamp),
    .arm_reload(arm_reload), .tx_inc(tx_inc), .cfg_q(cfg_q), .tc_q(tc_q)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model: plain integers, updated once per rising edge
  int m_gen[NG];
  int m_tc, m_frc, m_viol, m_hec;
  logic [31:0] m_rd;
  bit m_rl, m_inc;

  function automatic int stat_word(input int k);
    return int'(status_in[k*16 +: 16]);
  endfunction

  function automatic int low_value(input int code);
    case (code)
      0, 1, 2: return m_gen[code];
      3:       return m_tc;
      4:       return m_frc;
      5:       return m_viol;
      6:       return m_hec;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_gen[i]) m_gen[i] = 0;
      m_tc = 0; m_frc = 0; m_viol = 0; m_hec = 0; m_rd = '0; m_rl = 0; m_inc = 0;
    end else begin
      int hi, lo;
      bit wipe;
      lo = low_value(int'(rd_lo_sel));
      hi = (rd_hi_sel == 0) ? 0 : stat_word(int'(rd_hi_sel) - 1);
      if (rd_stb) m_rd = {hi[15:0], lo[15:0]};
      m_rl  = rd_stb && rd_lo_sel == 0 && !rd_noreload;
      m_inc = wr_inc && (reg_wr || mem_wr);
      if (wr_data[ENB] && ((reg_wr && (wr_tc_sel || wr_inc)) || (mem_wr && wr_inc)))
        m_tc = int'(wr_data[31:16]);
      if (reg_wr) foreach (m_gen[i]) if (wr_mask[i]) m_gen[i] = int'(wr_data[15:0]);
      wipe = rd_stb && rd_clear && rd_hi_sel != 0;
      if (wipe) begin m_viol = 0; m_hec = 0; end
      else begin
        if (viol_evt && m_viol < CMAX) m_viol++;
        if (hec_evt && m_hec < CMAX) m_hec++;
      end
      m_frc = (m_frc + 1) % (1 << FW);
    end
  end

  // Per-cycle comparison at the falling edge; stimulus moves 2 ns later
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R3 rd_data", 64'(rd_data), 64'(m_rd));
      chk("R2 timestamp", 64'(timestamp), 64'({status_in[15:0], 16'(m_frc)}));
      chk("R4 arm_reload", 64'(arm_reload), 64'(m_rl));
      chk("R8 tx_inc", 64'(tx_inc), 64'(m_inc));
      chk("R9 tc_q", 64'(tc_q), 64'(m_tc));
      for (int i = 0; i < NG; i++)
        chk("R7 cfg_q", 64'(cfg_q[i*16 +: 16]), 64'(m_gen[i]));
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic quiet();
    rd_stb = 0; rd_noreload = 0; rd_clear = 0; reg_wr = 0; mem_wr = 0;
    wr_tc_sel = 0; wr_inc = 0; wr_mask = '0; viol_evt = 0; hec_evt = 0;
  endtask

  task automatic do_read(input int lo, input int hi, input bit nr, input bit cl);
    rd_stb = 1; rd_lo_sel = 3'(lo); rd_hi_sel = 2'(hi); rd_noreload = nr; rd_clear = cl;
    tick(); quiet();
  endtask

  task automatic do_wr(input bit r, input bit m, input logic [NG-1:0] mk,
                       input bit tsel, input bit inc, input logic [31:0] d);
    reg_wr = r; mem_wr = m; wr_mask = mk; wr_tc_sel = tsel; wr_inc = inc; wr_data = d;
    tick(); quiet();
  endtask

  initial begin
    #20000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    status_in = {16'h3333, 16'h2222, 16'h1111};
    repeat (3) tick();
    // R1: reset state
    chk("R1 rd_data", 64'(rd_data), 0);
    chk("R1 cfg_q", 64'(cfg_q), 0);
    chk("R1 tc_q", 64'(tc_q), 0);
    chk("R1 strobes", 64'({arm_reload, tx_inc}), 0);
    chk("R1 timestamp low", 64'(timestamp[15:0]), 0);
    rst_n = 1; cmp_on = 1;
    tick();

    // R7: multi-register write, enable bit set but no counter qualifier (R9)
    do_wr(1, 0, 3'b101, 0, 0, 32'h1234ABCD);
    chk("R7 two regs", 64'(cfg_q), 64'({16'hABCD, 16'h0000, 16'hABCD}));
    chk("R9 no qualifier", 64'(tc_q), 0);
    // R9: select without enable, then with enable
    do_wr(1, 0, 3'b000, 1, 0, 32'h55AA0000);
    chk("R9 no enable", 64'(tc_q), 0);
    do_wr(1, 0, 3'b010, 1, 0, 32'h55AA8000);
    chk("R9 select+enable", 64'(tc_q), 64'h55AA);
    chk("R7 single reg", 64'(cfg_q[31:16]), 64'h8000);
    // R8/R9: memory write with increment and enable
    do_wr(0, 1, 3'b111, 1, 1, 32'h77778001);
    chk("R8 mem inc", 64'(tx_inc), 1);
    chk("R9 mem inc load", 64'(tc_q), 64'h7777);
    chk("R7 mem no reg", 64'(cfg_q), 64'({16'hABCD, 16'h8000, 16'hABCD}));
    do_wr(0, 1, 3'b000, 1, 0, 32'h99998000);
    chk("R9 mem select only", 64'(tc_q), 64'h7777);
    chk("R8 no inc", 64'(tx_inc), 0);

    // R3/R4: sweep of select codes and flags
    for (int lo = 0; lo < 8; lo++)
      for (int hi = 0; hi < 4; hi++)
        for (int nr = 0; nr < 2; nr++) begin
          do_read(lo, hi, nr[0], 0);
          if (lo == 0) chk("R4 reload", 64'(arm_reload), 64'(!nr[0]));
          else         chk("R4 other code", 64'(arm_reload), 0);
        end
    do_read(3, 2, 0, 0);
    chk("R3 tc and status1", 64'(rd_data), 64'h22227777);
    tick();
    chk("R3 hold", 64'(rd_data), 64'h22227777);

    // R6: saturation
    viol_evt = 1; repeat (CMAX + 5) tick(); quiet();
    hec_evt = 1; repeat (3) tick(); quiet();
    do_read(5, 1, 0, 0);
    chk("R6 viol saturated", 64'(rd_data), 64'h1111000F);
    // R5: clear with high code 0 is ignored
    do_read(6, 0, 0, 1);
    chk("R5 clear ignored read", 64'(rd_data), 64'h00000003);
    do_read(5, 0, 0, 0);
    chk("R5 clear ignored", 64'(rd_data[15:0]), 64'hF);
    // R5: effective clear returns old value, then zero
    do_read(5, 3, 0, 1);
    chk("R5 pre-clear value", 64'(rd_data), 64'h3333000F);
    do_read(6, 0, 0, 0);
    chk("R5 hec cleared", 64'(rd_data[15:0]), 0);
    // R10: event coincident with clear
    viol_evt = 1; do_read(4, 1, 0, 1);
    do_read(5, 0, 0, 0);
    chk("R10 clear wins", 64'(rd_data[15:0]), 0);

    // Mixed random traffic (wraps the free-running counter, R2)
    for (int n = 0; n < 3000; n++) begin
      rd_stb = ($urandom % 3) == 0;
      rd_lo_sel = 3'($urandom); rd_hi_sel = 2'($urandom);
      rd_noreload = 1'($urandom); rd_clear = ($urandom % 8) == 0;
      reg_wr = ($urandom % 4) == 0; mem_wr = ($urandom % 4) == 0;
      wr_mask = NG'($urandom); wr_tc_sel = 1'($urandom); wr_inc = 1'($urandom);
      wr_data = $urandom;
      viol_evt = 1'($urandom); hec_evt = ($urandom % 3) == 0;
      status_in = {16'($urandom), 16'($urandom), 16'($urandom)};
      tick();
    end
    quiet(); tick();
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule